// File: doc/BRIEF.md
# Hypercube Recursive Matrix Transposer

This block holds an n×n matrix (n = 2^Q) in an array of n² processing elements and transposes it in place. Element r holds the entry in row i and column j with r = i·n + j: the upper Q bits of r give the row and the lower Q bits give the column. Each element has a data register A and a buffer register B. An element exchanges values only with the elements whose index differs from its own in exactly one bit, so the links form a hypercube.

A transpose runs Q iterations, with the bit index m stepping from 2Q-1 down to Q. Each iteration has two one-cycle sub-steps. In the **send** sub-step, each element whose index bits m and m-Q differ writes its A into the B register of its neighbour across bit m. In the **return** sub-step, each element whose bits m and m-Q are equal writes its B into the A register of its neighbour across bit m-Q. The first iteration swaps the top-right and bottom-left quadrants. Each later iteration does the same swap inside sub-blocks half the size of the previous ones.

The controller has four states. `ST_IDLE` is entered on reset or on a load. `ST_SEND` and `ST_RETURN` are the two sub-steps. `ST_FIN` holds the result with the done flag raised. The transitions are:
- IDLE→SEND and FIN→SEND on start.
- SEND→RETURN always.
- RETURN→SEND while m > Q, with m decremented.
- RETURN→FIN when m = Q.
- Any state→IDLE on load.

The matrix is written through one wide parallel load port and read back through one wide readout port. Starting again from FIN transposes the matrix back to its original layout.

Top module: `hct_transposer`

## Requirements
- R1: Reset clears every A and B register, `busy` and `done`. A cycle with `load` high writes `load_data[r*W +: W]` into the A register of element r and returns the controller to idle. `rd_data[r*W +: W]` always shows the A register of element r.
- R2: `start` sampled high in idle or finished state, with `load` low, sets `busy` from the next cycle. `done` rises exactly 2·Q clock edges after the edge that sampled `start`. `busy` and `done` are never high together. `done` stays high, with the contents unchanged, until the next start or load.
- R3: When `done` is high, readout slice j·n+i holds the value that was loaded into slice i·n+j, for every row i (upper Q index bits) and column j (lower Q index bits).
- R4: The iterations run in the order m = 2Q-1 down to Q. Two edges after the start edge, the top-right and bottom-left quadrants have been swapped. For n = 4 with rows a b c d / e f g h / i j k l / m n o p, the readout at that point is a b i j / e f m n / c d k l / g h o p.
- R5: An element takes a new B only in a send sub-step in which its bits m and m-Q are equal. It takes a new A only in a return sub-step in which those bits differ. Otherwise it holds both registers. Diagonal elements therefore never change outside a load.
- R6: A second start after `done` transposes the matrix back, so the readout equals the loaded matrix.
- R7: `start` while `busy` is high has no effect. The run finishes at its original time with the transposed result.
- R8: `load` during a run aborts it: `busy` and `done` are low in the next cycle and the readout shows the newly loaded matrix.
- R9: The same structure transposes correctly for other Q values, including Q = 3 (8×8, 64 elements).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Parallel load of all A registers; aborts any run |
| load_data | input | N·W | Slice r is the value for element r |
| start | input | 1 | Begins a transpose from idle or finished state |
| busy | output | 1 | A transpose is in progress |
| done | output | 1 | The last transpose has completed |
| rd_data | output | N·W | Slice r is the A register of element r |

## Verification
The bench builds one instance with Q = 2 and W = 8. This size reaches the 4×4 intermediate quadrant layout after the first iteration, the 4-edge completion timing, start during both sub-steps, an abort by load and the round trip back to the original matrix. A second instance with Q = 3 (64 elements) runs three iterations. It exercises the decrementing bit index past its first step and the neighbour selection across three candidate links per element.

// File: rtl/hct_pkg.sv
package hct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_RETURN = 2'd2,
        ST_FIN    = 2'd3
    } hct_state_e;
endpackage

// File: rtl/hct_ctrl.sv
module hct_ctrl
    import hct_pkg::*;
#(
    parameter int Q  = 2,
    parameter int MW = $clog2(2*Q)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          start,
    output logic          step_send,
    output logic          step_return,
    output logic [MW-1:0] m_idx,
    output logic          busy,
    output logic          done
);
    localparam logic [MW-1:0] M_TOP = MW'(2*Q-1);
    localparam logic [MW-1:0] M_BOT = MW'(Q);

    hct_state_e    st_q, st_d;
    logic [MW-1:0] m_q, m_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            m_q  <= M_TOP;
        end else begin
            st_q <= st_d;
            m_q  <= m_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        m_d  = m_q;
        if (load) begin
            st_d = ST_IDLE;
            m_d  = M_TOP;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        st_d = ST_SEND;
                        m_d  = M_TOP;
                    end
                end
                ST_SEND:   st_d = ST_RETURN;
                ST_RETURN: begin
                    if (m_q == M_BOT) begin
                        st_d = ST_FIN;
                    end else begin
                        st_d = ST_SEND;
                        m_d  = m_q - MW'(1);
                    end
                end
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        step_send   = 1'b0;
        step_return = 1'b0;
        busy        = 1'b0;
        done        = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_SEND:   begin step_send   = 1'b1; busy = 1'b1; end
            ST_RETURN: begin step_return = 1'b1; busy = 1'b1; end
            ST_FIN:    done = 1'b1;
            default:   ;
        endcase
    end
    assign m_idx = m_q;

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !load) |=> busy);
    p_send_then_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_send && !load) |=> (step_return && $stable(m_idx)));
    p_m_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (m_idx >= M_BOT && m_idx <= M_TOP));
    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_send && start && !load) |=> step_return);
    p_load_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!busy && !done));
endmodule

// File: rtl/hct_pe.sv
module hct_pe #(
    parameter int Q   = 2,
    parameter int W   = 8,
    parameter int IDX = 0,
    parameter int MW  = $clog2(2*Q)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          step_send,
    input  logic          step_return,
    input  logic [MW-1:0] m_idx,
    input  logic [W-1:0]  nb_a,
    input  logic [W-1:0]  nb_b,
    output logic [W-1:0]  a_out,
    output logic [W-1:0]  b_out
);
    localparam int             IW = 2*Q;
    localparam logic [IW-1:0]  ID = IW'(IDX);
    localparam int             ROW = IDX >> Q;
    localparam int             COL = IDX & ((1 << Q) - 1);

    logic [W-1:0] a_q, b_q;
    logic         bit_hi, bit_lo, bits_eq;

    always_comb begin
        bit_hi  = ID[m_idx];
        bit_lo  = ID[m_idx - MW'(Q)];
        bits_eq = (bit_hi == bit_lo);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= load_val;
            b_q <= '0;
        end else if (step_send && bits_eq) begin
            b_q <= nb_a;
        end else if (step_return && !bits_eq) begin
            a_q <= nb_b;
        end
    end

    assign a_out = a_q;
    assign b_out = b_q;

    p_a_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_return) |=> $stable(a_out));
    p_b_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_send) |=> $stable(b_out));

    generate
        if (ROW == COL) begin : g_diag
            p_diag_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !load |=> $stable(a_out));
        end
    endgenerate
endmodule

// File: rtl/hct_transposer.sv
module hct_transposer #(
    parameter int Q = 2,
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [(1<<(2*Q))*W-1:0] load_data,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic [(1<<(2*Q))*W-1:0] rd_data
);
    localparam int NE = 1 << (2*Q);
    localparam int IW = 2*Q;
    localparam int MW = $clog2(2*Q);

    logic          step_send, step_return;
    logic [MW-1:0] m_idx;
    logic [W-1:0]  a_bus [NE];
    logic [W-1:0]  b_bus [NE];

    hct_ctrl #(.Q(Q), .MW(MW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .start       (start),
        .step_send   (step_send),
        .step_return (step_return),
        .m_idx       (m_idx),
        .busy        (busy),
        .done        (done)
    );

    generate
        for (genvar g = 0; g < NE; g++) begin : g_pe
            logic [W-1:0] nb_a, nb_b;

            // select the link across bit m (for A) and bit m-Q (for B)
            always_comb begin
                nb_a = '0;
                nb_b = '0;
                for (int k = Q; k < 2*Q; k++) begin
                    logic [IW-1:0] ia, ib;
                    ia = IW'(g) ^ (IW'(1) << k);
                    ib = IW'(g) ^ (IW'(1) << (k - Q));
                    if (m_idx == MW'(k)) begin
                        nb_a = a_bus[ia];
                        nb_b = b_bus[ib];
                    end
                end
            end

            hct_pe #(.Q(Q), .W(W), .IDX(g), .MW(MW)) u_pe (
                .clk         (clk),
                .rst_n       (rst_n),
                .load        (load),
                .load_val    (load_data[g*W +: W]),
                .step_send   (step_send),
                .step_return (step_return),
                .m_idx       (m_idx),
                .nb_a        (nb_a),
                .nb_b        (nb_b),
                .a_out       (a_bus[g]),
                .b_out       (b_bus[g])
            );

            assign rd_data[g*W +: W] = a_bus[g];
        end
    endgenerate

    p_done_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load && !start) |=> (done && $stable(rd_data)));
endmodule

// File: tb/sim_hct_transposer.sv
`timescale 1ns/1ps
module sim_hct_transposer;
    localparam int Q0 = 2, S0 = 4, N0 = 16, W = 8;
    localparam int Q1 = 3, S1 = 8, N1 = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            load0 = 1'b0, start0 = 1'b0, busy0, done0;
    logic [N0*W-1:0] ld0 = '0, rd0;
    logic            load1 = 1'b0, start1 = 1'b0, busy1, done1;
    logic [N1*W-1:0] ld1 = '0, rd1;

    hct_transposer #(.Q(Q0), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load0), .load_data(ld0),
        .start(start0), .busy(busy0), .done(done0), .rd_data(rd0));
    hct_transposer #(.Q(Q1), .W(W)) u1 (
        .clk(clk), .rst_n(rst_n), .load(load1), .load_data(ld1),
        .start(start1), .busy(busy1), .done(done1), .rd_data(rd1));

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] src0 [N0];
    logic [W-1:0] src1 [N1];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_mat0();
        for (int r = 0; r < N0; r++) ld0[r*W +: W] = src0[r];
        load0 = 1'b1;
        @(negedge clk);
        load0 = 1'b0;
    endtask

    task automatic pulse_start0();
        start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
    endtask

    task automatic check_transposed0(input string tag);
        for (int r = 0; r < N0; r++) begin
            int i, j;
            i = r >> Q0;
            j = r & (S0 - 1);
            check(tag, 32'(rd0[(j*S0+i)*W +: W]), 32'(src0[r]));
        end
    endtask

    task automatic check_original0(input string tag);
        for (int r = 0; r < N0; r++) check(tag, 32'(rd0[r*W +: W]), 32'(src0[r]));
    endtask

    task automatic check_diag0(input string tag);
        for (int d = 0; d < S0; d++)
            check(tag, 32'(rd0[(d*S0+d)*W +: W]), 32'(src0[d*S0+d]));
    endtask

    task automatic t_reset();
        check("R1 reset busy", 32'(busy0), 0);
        check("R1 reset done", 32'(done0), 0);
        check("R1 reset readout", 32'(rd0 == '0), 1);
    endtask

    task automatic t_load();
        for (int r = 0; r < N0; r++) src0[r] = W'(r * 7 + 3);
        load_mat0();
        check_original0("R1 load slice");
        check("R1 load done low", 32'(done0), 0);
    endtask

    task automatic t_quadrant_example();
        int mid [N0] = '{0,1,8,9, 4,5,12,13, 2,3,10,11, 6,7,14,15};
        for (int r = 0; r < N0; r++) src0[r] = W'(8'h61 + r);
        load_mat0();
        pulse_start0();
        check("R2 busy after start", 32'(busy0), 1);
        check("R2 done low while busy", 32'(done0), 0);
        @(negedge clk);
        check_diag0("R5 diag after send");
        @(negedge clk);
        for (int r = 0; r < N0; r++)
            check("R4 first iteration layout", 32'(rd0[r*W +: W]), 32'(src0[mid[r]]));
        check_diag0("R5 diag after iteration");
        @(negedge clk);
        check("R2 done not early", 32'(done0), 0);
        @(negedge clk);
        check("R2 done at 2Q edges", 32'(done0), 1);
        check("R2 busy clear at done", 32'(busy0), 0);
        check_transposed0("R3 transposed");
        repeat (3) @(negedge clk);
        check("R2 done held", 32'(done0), 1);
        check_transposed0("R2 contents held");
    endtask

    task automatic t_round_trip();
        pulse_start0();
        check("R6 busy on restart", 32'(busy0), 1);
        repeat (4) @(negedge clk);
        check("R6 done again", 32'(done0), 1);
        check_original0("R6 round trip");
    endtask

    task automatic t_start_while_busy();
        for (int r = 0; r < N0; r++) src0[r] = W'(8'hF0 - r * 5);
        load_mat0();
        pulse_start0();
        start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
        start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
        @(negedge clk);
        check("R7 done not early", 32'(done0), 0);
        @(negedge clk);
        check("R7 done on time", 32'(done0), 1);
        check_transposed0("R7 result unaffected");
    endtask

    task automatic t_load_abort();
        for (int r = 0; r < N0; r++) src0[r] = W'(r * 11 + 1);
        load_mat0();
        pulse_start0();
        @(negedge clk);
        for (int r = 0; r < N0; r++) src0[r] = W'(8'h80 + r * 3);
        load_mat0();
        check("R8 busy cleared", 32'(busy0), 0);
        check("R8 done cleared", 32'(done0), 0);
        check_original0("R8 new contents");
        pulse_start0();
        repeat (4) @(negedge clk);
        check("R8 done after restart", 32'(done0), 1);
        check_transposed0("R8 transposed after abort");
    endtask

    task automatic t_q3();
        for (int r = 0; r < N1; r++) begin
            src1[r] = W'(r * 5 + 3);
            ld1[r*W +: W] = src1[r];
        end
        load1 = 1'b1;
        @(negedge clk);
        load1 = 1'b0;
        start1 = 1'b1;
        @(negedge clk);
        start1 = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 q3 done not early", 32'(done1), 0);
        @(negedge clk);
        check("R9 q3 done", 32'(done1), 1);
        for (int r = 0; r < N1; r++) begin
            int i, j;
            i = r >> Q1;
            j = r & (S1 - 1);
            check("R9 q3 transposed", 32'(rd1[(j*S1+i)*W +: W]), 32'(src1[r]));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_quadrant_example();
        t_round_trip();
        t_start_while_busy();
        t_load_abort();
        t_q3();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule